// File: doc/BRIEF.md
# Ordered Speculative Read-Set Tracker

This block runs one speculative transaction on behalf of a single processor. Each load the processor issues inside the open transaction has its line address recorded in a small associative read-set table. A transaction ends with exactly one store. That store is not written to memory straight away. It is parked in a one-entry buffer while the unit waits for its commit slot.

Commits are serialised by a global turn counter. The unit may commit only when that counter equals its own transaction sequence number. On commit, the parked store goes out on the shared broadcast outputs for one cycle, so that other units can test it against their own read sets.

A write snooped from another unit that matches any recorded line cancels the transaction. When that happens, the parked store is dropped, a one-cycle restart pulse is raised and nothing is written back. No register values pass between transactions, so the block holds no architectural state beyond the read set and the parked store.

Top module: `stx_unit`

## Requirements
- R1: After synchronous reset, `restart`, `bc_valid` and `ld_stall` are all 0 and the read set is empty.
- R2: A buffered store is not broadcast while `commit_turn` differs from `txn_seq`; `bc_valid` stays 0 for as long as the turn is withheld.
- R3: In a clock edge where a store is buffered, `commit_turn == txn_seq` and no snoop hit occurs, `bc_valid` is 1 for exactly the following cycle, with `bc_addr`/`bc_data` equal to the buffered store.
- R4: A snooped write (`snp_valid` = 1) whose line address equals a recorded load address makes `restart` 1 in the next cycle, whether or not a store is buffered. The buffered store is discarded and is never broadcast, even if the turn arrives later.
- R5: A snooped write to a line not in the read set has no effect: no restart and no change to a pending commit.
- R6: If a snoop hit and a commit grant fall in the same edge, the result is an abort: `restart` is 1 and `bc_valid` is 0 in the next cycle.
- R7: The read set holds 8 distinct lines. When it is full and the unit is not the oldest (`commit_turn != txn_seq`), a load to a new line raises `ld_stall` combinationally. A load to a line already recorded does not stall.
- R8: When the unit is the oldest (`commit_turn == txn_seq`), a load to a new line is accepted even with a full read set (`ld_stall` = 0).
- R9: After a commit or an abort, the read set is empty from the very next cycle: a snoop to any line recorded in the earlier transaction causes no restart.
- R10: While a store is buffered and waiting for its turn, any load request is held off with `ld_stall` = 1.
- R11: `restart` and `bc_valid` are single-cycle pulses and are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_seq | input | 4 | Sequence number of the transaction this unit runs |
| commit_turn | input | 4 | Global commit turn counter |
| ld_valid | input | 1 | Load request from the processor |
| ld_addr | input | 16 | Line address of the load |
| ld_stall | output | 1 | Load must be held and retried |
| st_valid | input | 1 | Ending store of the transaction |
| st_addr | input | 16 | Line address of the ending store |
| st_data | input | 32 | Data of the ending store |
| snp_valid | input | 1 | Write broadcast by another unit |
| snp_addr | input | 16 | Line address of the snooped write |
| restart | output | 1 | One-cycle pulse: transaction aborted, restart it |
| bc_valid | output | 1 | One-cycle pulse: committed store on the bus |
| bc_addr | output | 16 | Line address of the committed store |
| bc_data | output | 32 | Data of the committed store |

## Verification
The assertions rely on a few assumptions about the inputs. Snooped writes never come from this unit's own broadcast. `txn_seq` does not change while a transaction is open. The processor holds a stalled load and issues no load in the same cycle as its ending store. The stimulus respects all of these. It changes the sequence number never, drives loads and stores in separate cycles, and keeps each stalled request only for the cycle used to observe `ld_stall`. The commit grant is produced by toggling `commit_turn` between a foreign value and the unit's own number.

// File: rtl/stx_pkg.sv
package stx_pkg;
    parameter int ADDR_W   = 16;
    parameter int DATA_W   = 32;
    parameter int SEQ_W    = 4;
    parameter int RS_DEPTH = 8;

    typedef logic [ADDR_W-1:0] line_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [SEQ_W-1:0]  seq_t;

    typedef enum logic {PH_RUN, PH_WAIT} phase_t;

    typedef struct packed {
        line_t addr;
        word_t data;
    } st_entry_t;

    function automatic logic turn_is_mine(seq_t turn, seq_t mine);
        return turn == mine;
    endfunction
endpackage

// File: rtl/stx_readset.sv
module stx_readset
    import stx_pkg::*;
#(
    parameter int DEPTH = RS_DEPTH
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  ins_en,
    input  line_t ins_addr,
    input  logic  snp_valid,
    input  line_t snp_addr,
    output logic  hit,
    output logic  full,
    output logic  present
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] vld;
    line_t            tag [DEPTH];
    logic [CW-1:0]    cnt;
    logic [DEPTH-1:0] snp_m;
    logic [DEPTH-1:0] ins_m;
    logic             do_ins;

    assign full    = (cnt == CW'(DEPTH));
    assign present = |ins_m;
    assign hit     = snp_valid && (|snp_m);
    assign do_ins  = ins_en && !present && !full;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        assign snp_m[g] = vld[g] && (tag[g] == snp_addr);
        assign ins_m[g] = vld[g] && (tag[g] == ins_addr);

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                vld[g] <= 1'b0;
            end else if (do_ins && cnt == CW'(g)) begin
                vld[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (do_ins && cnt == CW'(g)) begin
                tag[g] <= ins_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (do_ins) begin
            cnt <= cnt + CW'(1);
        end
    end

    // R7: occupancy never exceeds the table size
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R9: a clear empties the whole table in one cycle
    a_r9_clear_one_cycle: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0 && vld == '0));

    // R7: a full table only drains through a clear
    a_r7_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full && !clr) |=> full);
endmodule

// File: rtl/stx_commit_ctrl.sv
module stx_commit_ctrl
    import stx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  seq_t  txn_seq,
    input  seq_t  commit_turn,
    input  logic  ld_valid,
    input  logic  st_valid,
    input  line_t st_addr,
    input  word_t st_data,
    input  logic  rs_hit,
    input  logic  rs_full,
    input  logic  rs_present,
    output logic  rs_ins,
    output logic  rs_clr,
    output logic  ld_stall,
    output logic  restart,
    output logic  bc_valid,
    output line_t bc_addr,
    output word_t bc_data
);
    phase_t    ph;
    st_entry_t pend;
    st_entry_t bc_q;
    logic      granted;
    logic      abort_now;
    logic      commit_now;

    assign granted    = turn_is_mine(commit_turn, txn_seq);
    assign abort_now  = rs_hit;
    assign commit_now = (ph == PH_WAIT) && granted && !rs_hit;
    assign ld_stall   = ld_valid && ((ph == PH_WAIT) ||
                                     (rs_full && !rs_present && !granted));
    assign rs_ins     = ld_valid && (ph == PH_RUN) && !ld_stall && !abort_now;
    assign rs_clr     = abort_now || commit_now;
    assign bc_addr    = bc_q.addr;
    assign bc_data    = bc_q.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_RUN;
            pend     <= '0;
            bc_q     <= '0;
            restart  <= 1'b0;
            bc_valid <= 1'b0;
        end else begin
            restart  <= abort_now;
            bc_valid <= commit_now;
            if (commit_now) begin
                bc_q <= pend;
            end
            if (abort_now || commit_now) begin
                ph <= PH_RUN;
            end else if (ph == PH_RUN && st_valid) begin
                pend <= '{addr: st_addr, data: st_data};
                ph   <= PH_WAIT;
            end
        end
    end

    // R2: a broadcast only follows an edge where the turn was ours
    a_r2_turn_before_bc: assert property (@(posedge clk) disable iff (rst)
        bc_valid |-> $past(commit_turn == txn_seq));

    // R6: a snoop hit is never followed by a broadcast
    a_r6_hit_blocks_bc: assert property (@(posedge clk) disable iff (rst)
        rs_hit |=> !bc_valid);

    // R11: pulses last one cycle and exclude each other
    a_r11_restart_pulse: assert property (@(posedge clk) disable iff (rst)
        restart |=> !restart);
    a_r11_bc_pulse: assert property (@(posedge clk) disable iff (rst)
        bc_valid |=> !bc_valid);
    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(restart && bc_valid));
endmodule

// File: rtl/stx_unit.sv
module stx_unit
    import stx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SEQ_W-1:0]  txn_seq,
    input  logic [SEQ_W-1:0]  commit_turn,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_stall,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              restart,
    output logic              bc_valid,
    output logic [ADDR_W-1:0] bc_addr,
    output logic [DATA_W-1:0] bc_data
);
    logic rs_hit, rs_full, rs_present, rs_ins, rs_clr;

    stx_readset #(.DEPTH(RS_DEPTH)) u_rs (
        .clk       (clk),
        .rst       (rst),
        .clr       (rs_clr),
        .ins_en    (rs_ins),
        .ins_addr  (ld_addr),
        .snp_valid (snp_valid),
        .snp_addr  (snp_addr),
        .hit       (rs_hit),
        .full      (rs_full),
        .present   (rs_present)
    );

    stx_commit_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .txn_seq     (txn_seq),
        .commit_turn (commit_turn),
        .ld_valid    (ld_valid),
        .st_valid    (st_valid),
        .st_addr     (st_addr),
        .st_data     (st_data),
        .rs_hit      (rs_hit),
        .rs_full     (rs_full),
        .rs_present  (rs_present),
        .rs_ins      (rs_ins),
        .rs_clr      (rs_clr),
        .ld_stall    (ld_stall),
        .restart     (restart),
        .bc_valid    (bc_valid),
        .bc_addr     (bc_addr),
        .bc_data     (bc_data)
    );

    // R1: nothing is signalled in the cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!restart && !bc_valid));
endmodule

// File: tb/tb_stx_unit.sv
`timescale 1ns/1ps
module tb_stx_unit;
    import stx_pkg::*;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    seq_t  txn_seq = 4'd3;
    seq_t  commit_turn = 4'd0;
    logic  ld_valid = 1'b0;
    line_t ld_addr = '0;
    logic  st_valid = 1'b0;
    line_t st_addr = '0;
    word_t st_data = '0;
    logic  snp_valid = 1'b0;
    line_t snp_addr = '0;
    logic  ld_stall, restart, bc_valid;
    line_t bc_addr;
    word_t bc_data;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    stx_unit dut (
        .clk(clk), .rst(rst), .txn_seq(txn_seq), .commit_turn(commit_turn),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_stall(ld_stall),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .snp_valid(snp_valid), .snp_addr(snp_addr), .restart(restart),
        .bc_valid(bc_valid), .bc_addr(bc_addr), .bc_data(bc_data)
    );

    // behavioural reference
    line_t m_rs[$];
    bit    m_wait = 0;
    line_t m_sa;
    word_t m_sd;
    bit    m_restart = 0;
    bit    m_bcv = 0;
    line_t m_bca = '0;
    word_t m_bcd = '0;

    function automatic bit m_has(line_t a);
        foreach (m_rs[i]) if (m_rs[i] == a) return 1;
        return 0;
    endfunction

    function automatic bit m_stall();
        return ld_valid && (m_wait ||
               (m_rs.size() >= 8 && !m_has(ld_addr) && commit_turn != txn_seq));
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_rs.delete(); m_wait = 0; m_restart = 0; m_bcv = 0;
        end else begin
            bit hit, cmt, stl;
            stl = m_stall();
            hit = snp_valid && m_has(snp_addr);
            cmt = m_wait && (commit_turn == txn_seq) && !hit;
            m_restart = hit;
            m_bcv = cmt;
            if (cmt) begin m_bca = m_sa; m_bcd = m_sd; end
            if (hit || cmt) begin
                m_rs.delete(); m_wait = 0;
            end else if (!m_wait) begin
                if (ld_valid && !stl && !m_has(ld_addr) && m_rs.size() < 8)
                    m_rs.push_back(ld_addr);
                if (st_valid) begin m_sa = st_addr; m_sd = st_data; m_wait = 1; end
            end
        end
    end

    task automatic chk(bit ok, string r, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(restart == m_restart, cur_req, restart, m_restart);
            chk(bc_valid == m_bcv, cur_req, bc_valid, m_bcv);
            chk(ld_stall == m_stall(), cur_req, ld_stall, m_stall());
            if (m_bcv) begin
                chk(bc_addr == m_bca, cur_req, bc_addr, m_bca);
                chk(bc_data == m_bcd, cur_req, bc_data, m_bcd);
            end
        end
    end

    task automatic cyc();
        @(posedge clk); #2;
    endtask

    task automatic do_load(line_t a);
        ld_valid = 1; ld_addr = a; cyc(); ld_valid = 0;
    endtask

    task automatic do_store(line_t a, word_t d);
        st_valid = 1; st_addr = a; st_data = d; cyc(); st_valid = 0;
    endtask

    task automatic do_snoop(line_t a);
        snp_valid = 1; snp_addr = a; cyc(); snp_valid = 0;
    endtask

    task automatic finish_up();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        #1;
        chk(restart == 0, "R1", restart, 0);
        chk(bc_valid == 0, "R1", bc_valid, 0);
        chk(ld_stall == 0, "R1", ld_stall, 0);
        cyc();

        // commit path
        cur_req = "R2";
        do_load(16'h0A01); do_load(16'h0A02); do_load(16'h0A03);
        do_store(16'h0B00, 32'hCAFE_0001);
        cyc(); cyc();
        chk(bc_valid == 0, "R2", bc_valid, 0);
        cur_req = "R3";
        commit_turn = 4'd3; cyc();
        chk(bc_valid == 1, "R3", bc_valid, 1);
        chk(bc_addr == 16'h0B00, "R3", bc_addr, 16'h0B00);
        chk(bc_data == 32'hCAFE_0001, "R3", bc_data, 32'hCAFE_0001);
        commit_turn = 4'd0; cyc();
        chk(bc_valid == 0, "R3", bc_valid, 0);
        cur_req = "R9";
        do_snoop(16'h0A01);
        chk(restart == 0, "R9", restart, 0);

        // snoop miss and hit
        cur_req = "R5";
        do_load(16'h0C01); do_load(16'h0C02);
        do_snoop(16'h0C09);
        chk(restart == 0, "R5", restart, 0);
        cur_req = "R4";
        do_snoop(16'h0C02);
        chk(restart == 1, "R4", restart, 1);
        cur_req = "R11";
        cyc();
        chk(restart == 0, "R11", restart, 0);
        cur_req = "R9";
        do_snoop(16'h0C01);
        chk(restart == 0, "R9", restart, 0);

        // hit and grant together
        cur_req = "R6";
        do_load(16'h0D01);
        do_store(16'h0D80, 32'h1234_5678);
        snp_valid = 1; snp_addr = 16'h0D01; commit_turn = 4'd3; cyc();
        snp_valid = 0;
        chk(restart == 1, "R6", restart, 1);
        chk(bc_valid == 0, "R6", bc_valid, 0);
        cur_req = "R4";
        cyc();
        chk(bc_valid == 0, "R4", bc_valid, 0);
        commit_turn = 4'd0; cyc();

        // overflow
        cur_req = "R7";
        for (int i = 0; i < 8; i++) do_load(line_t'(16'h0E00 + i));
        ld_valid = 1; ld_addr = 16'h0E08; #1;
        chk(ld_stall == 1, "R7", ld_stall, 1);
        ld_addr = 16'h0E03; #1;
        chk(ld_stall == 0, "R7", ld_stall, 0);
        cyc();
        cur_req = "R8";
        commit_turn = 4'd3; ld_addr = 16'h0E08; #1;
        chk(ld_stall == 0, "R8", ld_stall, 0);
        cyc(); ld_valid = 0;
        do_store(16'h0E80, 32'hBEEF_0008);
        chk(bc_valid == 0, "R3", bc_valid, 0);
        cyc();
        chk(bc_valid == 1, "R3", bc_valid, 1);
        chk(bc_data == 32'hBEEF_0008, "R3", bc_data, 32'hBEEF_0008);
        commit_turn = 4'd0; cyc();

        // loads held while store waits
        cur_req = "R10";
        do_load(16'h0F01);
        do_store(16'h0F80, 32'h0000_00AA);
        ld_valid = 1; ld_addr = 16'h0F02; #1;
        chk(ld_stall == 1, "R10", ld_stall, 1);
        cyc(); ld_valid = 0;
        commit_turn = 4'd3; cyc();
        chk(bc_valid == 1, "R10", bc_valid, 1);
        chk(bc_addr == 16'h0F80, "R10", bc_addr, 16'h0F80);
        commit_turn = 4'd0; cyc();

        // abort while waiting, turn comes later
        cur_req = "R4";
        do_load(16'h1001);
        do_store(16'h1080, 32'h0000_0055);
        cyc();
        do_snoop(16'h1001);
        chk(restart == 1, "R4", restart, 1);
        commit_turn = 4'd3; cyc();
        chk(bc_valid == 0, "R4", bc_valid, 0);
        cyc();
        chk(bc_valid == 0, "R4", bc_valid, 0);
        commit_turn = 4'd0; cyc(); cyc();

        finish_up();
    end
endmodule